// File: doc/BRIEF.md
# Sequenced Trigger Match Unit

This block is the trigger stage of an embedded logic analyzer. It watches a group of monitored bus signals on every clock and compares the sample against up to two programmed conditions. A condition is either a per-bit pattern with optional edge tests, or a magnitude test against the whole group. An occurrence counter in front of each condition requires the condition to occur a programmed number of times before it counts as met.

With two units, the block forms an ordered sequence. The first condition must be met first, and only after that is the second condition evaluated. When the last step of the sequence is met, the block emits a one-cycle trigger pulse and latches a status flag. The flag stays set until the block is re-armed.

Parameters set the group width, the counter width, the unit type (basic, basic with edges, or full), the number of units and whether the group is enabled. The configuration inputs are meant to be held stable by the controller while the block is armed.

Top module: `seq_trigger`

## Requirements
- R1: Each monitored bit has a 2-bit mask code: 00 don't care, 01 bit must be 0, 10 bit must be 1, 11 edge test. A pattern in which every bit is 00 is met on every evaluated cycle.
- R2: The 3-bit operator selects the condition: 0 pattern met, 1 pattern not met, 2 group value greater than `lo`, 3 group value less than `lo`, 4 `lo` <= group value <= `hi` (both ends inclusive). Magnitude compares are unsigned.
- R3: Unit type 0 (basic) treats edge-coded bits as don't care and never meets operators 2 to 4. Type 1 adds edge tests. Type 2 supports every operator.
- R4: The edge kind is a 2-bit field: bit 0 selects rising, bit 1 selects falling, and 11 selects either edge. Each sample is compared with the sample of the previous cycle. No edge is detected on the first cycle after arm or reset.
- R5: A unit's occurrence counter advances only on cycles where its condition is true and the sequence is at that unit's step. The unit is met on the cycle the count reaches the programmed value, and a programmed value of 0 acts as 1. With counter width 0, one occurrence is enough.
- R6: With two units, unit 2 is evaluated only from the cycle after unit 1 is met. Unit 1 is not evaluated again until re-arm.
- R7: `trig_out` is a one-cycle pulse in the cycle after the final condition is met, and `triggered` is set with it. No further pulse occurs until re-arm.
- R8: A cycle with `arm` high clears the sequence step, both occurrence counters, the edge history, `trig_out` and `triggered`.
- R9: With the group disabled (ENABLE = 0), `trig_out` and `triggered` stay 0 whatever the configuration and inputs.
- R10: After reset, `trig_out` and `triggered` are 0 and the sequence is at unit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Synchronous re-arm; clears all trigger state |
| mon | input | W | Monitored signal group |
| u1_op | input | 3 | Unit 1 operator |
| u1_edge | input | 2 | Unit 1 edge kind |
| u1_mask | input | 2*W | Unit 1 per-bit mask codes |
| u1_lo | input | W | Unit 1 low / compare value |
| u1_hi | input | W | Unit 1 high bound for range |
| u1_cnt | input | max(CNT_W,1) | Unit 1 occurrence target |
| u2_op | input | 3 | Unit 2 operator |
| u2_edge | input | 2 | Unit 2 edge kind |
| u2_mask | input | 2*W | Unit 2 per-bit mask codes |
| u2_lo | input | W | Unit 2 low / compare value |
| u2_hi | input | W | Unit 2 high bound for range |
| u2_cnt | input | max(CNT_W,1) | Unit 2 occurrence target |
| trig_out | output | 1 | One-cycle trigger pulse |
| triggered | output | 1 | Latched trigger status |

## Verification
Most faults in the step register or the occurrence counters show up at the ports as a trigger pulse that comes one or more cycles too early or too late. They can also show up as a pulse for a sequence given out of order, or as a second pulse after the first. A stale edge history shows up as a trigger on the first cycle after arm. Because both outputs are registered, every such fault appears within one cycle of the edge where the wrong decision is made. Each directed scenario therefore checks the outputs on every cycle around the expected match.

// File: rtl/seqtrig_pkg.sv
package seqtrig_pkg;
  localparam logic [2:0] OP_EQ    = 3'd0;
  localparam logic [2:0] OP_NE    = 3'd1;
  localparam logic [2:0] OP_GT    = 3'd2;
  localparam logic [2:0] OP_LT    = 3'd3;
  localparam logic [2:0] OP_RANGE = 3'd4;

  localparam int TYPE_BASIC = 0;
  localparam int TYPE_EDGE  = 1;
  localparam int TYPE_FULL  = 2;

  typedef enum logic [1:0] {
    STEP_A    = 2'd0,
    STEP_B    = 2'd1,
    STEP_DONE = 2'd2
  } step_e;
endpackage

// File: rtl/seqtrig_compare.sv
module seqtrig_compare
  import seqtrig_pkg::*;
#(
  parameter int W     = 8,
  parameter int UTYPE = TYPE_FULL
) (
  input  logic [W-1:0]   cur,
  input  logic [W-1:0]   prev,
  input  logic           prev_vld,
  input  logic [2:0]     op,
  input  logic [1:0]     edge_kind,
  input  logic [2*W-1:0] mask,
  input  logic [W-1:0]   lo,
  input  logic [W-1:0]   hi,
  output logic           hit
);
  localparam bit EDGES_OK = (UTYPE >= TYPE_EDGE);
  localparam bit MAG_OK   = (UTYPE == TYPE_FULL);

  // one bit against its 2-bit code
  function automatic logic bit_ok(input logic [1:0] code, input logic c,
                                  input logic p, input logic v,
                                  input logic [1:0] ek);
    case (code)
      2'b00:   bit_ok = 1'b1;
      2'b01:   bit_ok = !c;
      2'b10:   bit_ok = c;
      default: bit_ok = EDGES_OK ? (v && ((ek[0] && !p && c) || (ek[1] && p && !c)))
                                 : 1'b1;
    endcase
  endfunction

  function automatic logic in_window(input logic [W-1:0] x, input logic [W-1:0] a,
                                     input logic [W-1:0] b);
    in_window = (x >= a) && (x <= b);
  endfunction

  logic pattern;

  always_comb begin
    pattern = 1'b1;
    for (int i = 0; i < W; i++)
      pattern = pattern & bit_ok(mask[2*i +: 2], cur[i], prev[i], prev_vld, edge_kind);
  end

  always_comb begin
    case (op)
      OP_EQ:    hit = pattern;
      OP_NE:    hit = !pattern;
      OP_GT:    hit = MAG_OK && (cur > lo);
      OP_LT:    hit = MAG_OK && (cur < lo);
      OP_RANGE: hit = MAG_OK && in_window(cur, lo, hi);
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/seqtrig_occur.sv
module seqtrig_occur #(
  parameter int CNT_W = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clr,
  input  logic                              cond,
  input  logic                              active,
  input  logic [((CNT_W > 0) ? CNT_W : 1)-1:0] target,
  output logic                              hit
);
  localparam int CW = (CNT_W > 0) ? CNT_W : 1;

  logic [CW-1:0] cnt_q;
  logic [CW:0]   want;
  logic [CW:0]   next_cnt;

  function automatic logic [CW:0] goal(input logic [CW-1:0] t);
    goal = (t == '0) ? (CW+1)'(1) : {1'b0, t};
  endfunction

  always_comb begin
    want     = goal(target);
    next_cnt = {1'b0, cnt_q} + (CW+1)'(1);
    hit      = cond && active && ((CNT_W == 0) || (next_cnt == want));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr)             cnt_q <= '0;
    else if (cond && active)  cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/seq_trigger.sv
module seq_trigger
  import seqtrig_pkg::*;
#(
  parameter int W         = 8,
  parameter int CNT_W     = 4,
  parameter int UNIT_TYPE = TYPE_FULL,
  parameter int NUM_UNITS = 2,
  parameter int ENABLE    = 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              arm,
  input  logic [W-1:0]                      mon,
  input  logic [2:0]                        u1_op,
  input  logic [1:0]                        u1_edge,
  input  logic [2*W-1:0]                    u1_mask,
  input  logic [W-1:0]                      u1_lo,
  input  logic [W-1:0]                      u1_hi,
  input  logic [((CNT_W > 0) ? CNT_W : 1)-1:0] u1_cnt,
  input  logic [2:0]                        u2_op,
  input  logic [1:0]                        u2_edge,
  input  logic [2*W-1:0]                    u2_mask,
  input  logic [W-1:0]                      u2_lo,
  input  logic [W-1:0]                      u2_hi,
  input  logic [((CNT_W > 0) ? CNT_W : 1)-1:0] u2_cnt,
  output logic                              trig_out,
  output logic                              triggered
);
  localparam int CW = (CNT_W > 0) ? CNT_W : 1;

  logic [W-1:0] prev_q;
  logic         prev_vld_q;
  step_e        step_q;
  logic [1:0]   unit_cond;
  logic [1:0]   unit_act;
  logic [1:0]   unit_hit;
  logic         fire;

  for (genvar g = 0; g < 2; g++) begin : g_unit
    logic [CW-1:0] tgt;
    assign tgt = (g == 0) ? u1_cnt : u2_cnt;
    assign unit_act[g] = (ENABLE != 0) && !arm &&
                         (step_q == ((g == 0) ? STEP_A : STEP_B));

    seqtrig_compare #(.W(W), .UTYPE(UNIT_TYPE)) u_cmp (
      .cur       (mon),
      .prev      (prev_q),
      .prev_vld  (prev_vld_q),
      .op        ((g == 0) ? u1_op   : u2_op),
      .edge_kind ((g == 0) ? u1_edge : u2_edge),
      .mask      ((g == 0) ? u1_mask : u2_mask),
      .lo        ((g == 0) ? u1_lo   : u2_lo),
      .hi        ((g == 0) ? u1_hi   : u2_hi),
      .hit       (unit_cond[g])
    );

    seqtrig_occur #(.CNT_W(CNT_W)) u_occ (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (arm),
      .cond   (unit_cond[g]),
      .active (unit_act[g]),
      .target (tgt),
      .hit    (unit_hit[g])
    );
  end

  assign fire = (NUM_UNITS > 1) ? unit_hit[1] : unit_hit[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else begin
      prev_q     <= mon;
      prev_vld_q <= !arm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= STEP_A;
    end else if (arm) begin
      step_q <= STEP_A;
    end else begin
      case (step_q)
        STEP_A:  if (unit_hit[0]) step_q <= (NUM_UNITS > 1) ? STEP_B : STEP_DONE;
        STEP_B:  if (unit_hit[1]) step_q <= STEP_DONE;
        default: step_q <= STEP_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_out  <= 1'b0;
      triggered <= 1'b0;
    end else if (arm) begin
      trig_out  <= 1'b0;
      triggered <= 1'b0;
    end else begin
      trig_out  <= fire;
      triggered <= triggered | fire;
    end
  end
endmodule

// File: rtl/seqtrig_chk.sv
module seqtrig_chk #(
  parameter int NUM_UNITS = 2,
  parameter int ENABLE    = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       arm,
  input logic       trig_out,
  input logic       triggered,
  input logic [1:0] step,
  input logic [1:0] unit_hit
);
  AST_NO_REPEAT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered && !arm) |=> !trig_out); // R7

  AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> triggered); // R7

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!trig_out && !triggered && step == 2'd0)); // R8

  AST_ORDERED_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (NUM_UNITS > 1 && trig_out) |-> $past(step) == 2'd1); // R6

  AST_U2_AFTER_U1: assert property (@(posedge clk) disable iff (!rst_n)
    unit_hit[1] |-> step == 2'd1); // R6

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_hit[0] && !arm) |=> step != 2'd0); // R6

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ENABLE == 0) |-> (!triggered && !trig_out)); // R9
endmodule

bind seq_trigger seqtrig_chk #(.NUM_UNITS(NUM_UNITS), .ENABLE(ENABLE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arm       (arm),
  .trig_out  (trig_out),
  .triggered (triggered),
  .step      (step_q),
  .unit_hit  (unit_hit)
);

// File: tb/test_seq_trigger.sv
`timescale 1ns/1ps
module test_seq_trigger;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic [W-1:0] mon = '0;
  logic [2:0] o1 = '0, o2 = '0;
  logic [1:0] e1 = '0, e2 = '0;
  logic [2*W-1:0] m1 = '0, m2 = '0;
  logic [W-1:0] l1 = '0, h1 = '0, l2 = '0, h2 = '0;
  logic [3:0] c1 = '0, c2 = '0;
  logic t_main, f_main, t_basic, f_basic, t_off, f_off;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  seq_trigger #(.W(W), .CNT_W(4), .UNIT_TYPE(2), .NUM_UNITS(2), .ENABLE(1)) i_seq_trigger (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mon(mon),
    .u1_op(o1), .u1_edge(e1), .u1_mask(m1), .u1_lo(l1), .u1_hi(h1), .u1_cnt(c1),
    .u2_op(o2), .u2_edge(e2), .u2_mask(m2), .u2_lo(l2), .u2_hi(h2), .u2_cnt(c2),
    .trig_out(t_main), .triggered(f_main));

  seq_trigger #(.W(W), .CNT_W(0), .UNIT_TYPE(0), .NUM_UNITS(1), .ENABLE(1)) i_basic (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mon(mon),
    .u1_op(o1), .u1_edge(e1), .u1_mask(m1), .u1_lo(l1), .u1_hi(h1), .u1_cnt(c1[0:0]),
    .u2_op(o2), .u2_edge(e2), .u2_mask(m2), .u2_lo(l2), .u2_hi(h2), .u2_cnt(c2[0:0]),
    .trig_out(t_basic), .triggered(f_basic));

  seq_trigger #(.W(W), .CNT_W(4), .UNIT_TYPE(2), .NUM_UNITS(2), .ENABLE(0)) i_off (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mon(mon),
    .u1_op(o1), .u1_edge(e1), .u1_mask(m1), .u1_lo(l1), .u1_hi(h1), .u1_cnt(c1),
    .u2_op(o2), .u2_edge(e2), .u2_mask(m2), .u2_lo(l2), .u2_hi(h2), .u2_cnt(c2),
    .trig_out(t_off), .triggered(f_off));

  function automatic logic [2*W-1:0] exact(input logic [W-1:0] v);
    logic [2*W-1:0] r;
    for (int i = 0; i < W; i++) r[2*i +: 2] = v[i] ? 2'b10 : 2'b01;
    return r;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic do_arm();
    arm = 1'b1; tick(); arm = 1'b0;
  endtask

  task automatic t_reset();
    chk(t_main, 1'b0, "R10", "trig_out after reset");
    chk(f_main, 1'b0, "R10", "triggered after reset");
  endtask

  task automatic t_sequence();
    o1 = 3'd0; m1 = exact(8'h5A); c1 = 4'd1;
    o2 = 3'd0; m2 = 16'h0003; e2 = 2'b01; c2 = 4'd1;
    mon = 8'h00; do_arm();
    mon = 8'h5A; tick();
    chk(t_main, 1'b0, "R6", "no fire on unit1 step");
    chk(f_basic, 1'b1, "R1", "single-unit exact match");
    mon = 8'h5B; tick();
    chk(t_main, 1'b1, "R6", "fire on rise after unit1");
    chk(f_main, 1'b1, "R7", "flag set with pulse");
    tick();
    chk(t_main, 1'b0, "R7", "pulse lasts one cycle");
    chk(f_main, 1'b1, "R7", "flag stays set");
    mon = 8'h5A; tick(); mon = 8'h5B; tick();
    chk(t_main, 1'b0, "R7", "no second pulse");
  endtask

  task automatic t_order();
    mon = 8'h00; do_arm();
    chk(f_main, 1'b0, "R8", "arm clears flag");
    mon = 8'h01; tick();
    chk(t_main, 1'b0, "R6", "edge before unit1 ignored");
    mon = 8'h5A; tick();
    mon = 8'h5A; tick();
    chk(t_main, 1'b0, "R4", "no edge when bit stable");
    mon = 8'h5B; tick();
    chk(t_main, 1'b1, "R6", "fire after ordered steps");
  endtask

  task automatic t_edges();
    o1 = 3'd0; m1 = 16'h0003; e1 = 2'b01; c1 = 4'd1;
    o2 = 3'd0; m2 = 16'h0000; c2 = 4'd1;
    mon = 8'h00; do_arm();
    mon = 8'h01; tick();
    chk(f_basic, 1'b1, "R3", "basic type treats edge bit as don't care");
    tick();
    chk(f_main, 1'b0, "R4", "no edge on first cycle after arm");
    mon = 8'h00; tick(); mon = 8'h01; tick();
    chk(t_main, 1'b0, "R4", "rise only advances step");
    tick();
    chk(t_main, 1'b1, "R1", "all don't care unit2 met");
    e1 = 2'b10; mon = 8'h01; do_arm();
    tick(); mon = 8'h00; tick(); tick();
    chk(t_main, 1'b1, "R4", "fall edge selected");
    e1 = 2'b11; mon = 8'h00; do_arm();
    tick(); mon = 8'h01; tick(); tick();
    chk(t_main, 1'b1, "R4", "either edge selected");
  endtask

  task automatic t_count();
    o1 = 3'd0; m1 = exact(8'h33); c1 = 4'd3;
    o2 = 3'd0; m2 = 16'h0000; c2 = 4'd0;
    mon = 8'h00; do_arm();
    mon = 8'h33; tick();
    chk(f_basic, 1'b1, "R5", "zero-width counter needs one occurrence");
    tick();
    chk(f_main, 1'b0, "R5", "two of three occurrences");
    mon = 8'h00; tick(); mon = 8'h33; tick();
    chk(t_main, 1'b0, "R5", "third occurrence only advances step");
    tick();
    chk(t_main, 1'b1, "R5", "fire after count, target 0 acts as 1");
    c1 = 4'd15; mon = 8'h33; do_arm();
    for (int i = 0; i < 15; i++) tick();
    chk(f_main, 1'b0, "R5", "max count not yet fired");
    tick();
    chk(t_main, 1'b1, "R5", "fire after max count");
  endtask

  task automatic t_arm_clear();
    o1 = 3'd0; m1 = exact(8'h33); c1 = 4'd2;
    o2 = 3'd0; m2 = 16'h0000; c2 = 4'd1;
    mon = 8'h00; do_arm();
    mon = 8'h33; tick();
    mon = 8'h00; do_arm();
    mon = 8'h33; tick(); mon = 8'h00; tick();
    chk(t_main, 1'b0, "R8", "counter cleared by arm");
    mon = 8'h33; tick(); tick();
    chk(t_main, 1'b1, "R8", "count restarts after arm");
  endtask

  task automatic t_magnitude();
    o1 = 3'd2; l1 = 8'h80; c1 = 4'd1;
    o2 = 3'd4; l2 = 8'h10; h2 = 8'h20; c2 = 4'd1;
    mon = 8'h00; do_arm();
    mon = 8'h80; tick(); mon = 8'h81; tick();
    mon = 8'h21; tick(); mon = 8'h0F; tick();
    chk(f_main, 1'b0, "R2", "outside range, equal not greater");
    mon = 8'h20; tick();
    chk(t_main, 1'b1, "R2", "inclusive range top");
    chk(f_basic, 1'b0, "R3", "basic type rejects magnitude");
    o1 = 3'd3; l1 = 8'h05; o2 = 3'd1; m2 = exact(8'h00);
    mon = 8'h09; do_arm();
    mon = 8'h05; tick(); mon = 8'h04; tick(); mon = 8'h00; tick();
    chk(f_main, 1'b0, "R2", "less-than strict, not-equal false");
    mon = 8'h40; tick();
    chk(t_main, 1'b1, "R2", "less-than then not-equal");
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_sequence();
    t_order();
    t_edges();
    t_count();
    t_arm_clear();
    t_magnitude();
    chk(f_off, 1'b0, "R9", "disabled group never triggers");
    chk(t_off, 1'b0, "R9", "disabled group no pulse");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule